// File: doc/BRIEF.md
# Serial Management Frame Engine

This block is the master end of a two-wire station-management link. It holds one 32-bit frame register that also acts as a circular shift register. A single write on a simple register bus loads a complete management frame and starts the transfer. The block then derives a slow management clock from the system clock. On each management clock period it sends the register's top bit out on the serial data pin and feeds one bit back in at the bottom.

After 32 periods the register has rotated all the way round, so every field is back where it was written. For a read frame, the 16-bit data field now holds the bits returned by the addressed device. Completion sets a done flag and raises a one-cycle interrupt. Software polls the flag or waits for the interrupt, then reads the register back. It can also read the register during a transfer, which shows the rotating contents as they are at that moment.

The frame layout is fixed by the serial protocol. From top to bottom it is: start code (bits 31:30, 01 for a valid frame), operation (bits 29:28), device address (27:23), register address (22:18), turnaround (17:16, written as 10) and data (15:0). The start code and turnaround values are not enforced by the block: whatever is written is sent.

Top module: `mdio_shift_master`

## Requirements
- R1: During and after a synchronous reset, the frame register reads zero. The done flag, interrupt, management clock and output enable are all low.
- R2: A bus write while idle loads the written word, which reads back on the next cycle. The same write clears the done flag and starts a transfer.
- R3: The management clock is the system clock divided by 64, with 32 system cycles low then 32 high. It is held low while idle, and each transfer begins with a low half.
- R4: The serial output is the register's bit 31, sent most significant bit first. It changes only when the management clock falls or when a frame is loaded. The input pin is sampled on the rising management clock.
- R5: After 32 shifts every bit is back in its written position. A frame whose operation field (bits 29:28) is not 10 ends with the register equal to the written word, whatever level the input pin shows.
- R6: For a read frame (operation bits 29:28 = 10), the 16 bits sampled in bit periods 16 to 31 replace bits 15:0, the first sampled bit landing in bit 15. Bits 31:16, including the turnaround field, keep their written values.
- R7: For non-read frames the output enable stays high for all 32 bit periods. For read frames it is high for bit periods 0 to 14 and low from period 15 (the second turnaround bit) to the end. It is low while idle.
- R8: The done flag is set 2048 system cycles after the loading edge. The interrupt is high for exactly that one cycle. The done flag stays set until the next transfer starts.
- R9: A bus read during a transfer returns the live register: after n completed shifts it equals the written word rotated left by n.
- R10: A bus write issued while a transfer is in progress is ignored. It does not change the register contents or disturb the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Frame word to load |
| bus_rdata | output | 32 | Live frame register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in, sampled from the pin |
| done | output | 1 | Management access complete flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hardest situation to reach is a bus write arriving in the middle of a frame, at a known shift count, while the register is part-way through its rotation. The bench counts system cycles from the loading edge to pick a point just after the fifth falling management clock edge. At that point it checks the rotated contents, issues a conflicting write, and then lets the scoreboard confirm that the original frame still completes intact. A second hard case is a pin that disagrees with the output while the output is enabled. The bench's device stub can invert the looped-back level, to show that non-read frames ignore it.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  // Operation codes carried in the frame's operation field.
  typedef enum logic [1:0] {
    OP_RSV_LO = 2'b00,
    OP_WRITE  = 2'b01,
    OP_READ   = 2'b10,
    OP_RSV_HI = 2'b11
  } mdio_op_e;

endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int HALF_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap     = run && (cnt == LAST);
  assign rise_stb = wrap && !mdc;
  assign fall_stb = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq #(
  parameter int FRAME_W = 32,
  parameter int DATA_W  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic start_rd,
  input  logic fall_stb,
  output logic busy,
  output logic cap_pin,
  output logic oe,
  output logic done,
  output logic irq
);

  localparam int IW = $clog2(FRAME_W);
  localparam logic [IW-1:0] LAST   = IW'(FRAME_W - 1);
  localparam logic [IW-1:0] OE_OFF = IW'(FRAME_W - DATA_W - 1);
  localparam logic [IW-1:0] CAP_ON = IW'(FRAME_W - DATA_W);

  logic [IW-1:0] idx;
  logic [IW-1:0] idx_nx;
  logic          rd;

  assign idx_nx  = idx + 1'b1;
  assign cap_pin = rd && (idx >= CAP_ON);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      rd   <= 1'b0;
      oe   <= 1'b0;
      done <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        rd   <= start_rd;
        oe   <= 1'b1;
        done <= 1'b0;
      end else if (busy && fall_stb) begin
        if (idx == LAST) begin
          busy <= 1'b0;
          idx  <= '0;
          rd   <= 1'b0;
          oe   <= 1'b0;
          done <= 1'b1;
          irq  <= 1'b1;
        end else begin
          idx <= idx_nx;
          oe  <= !(rd && (idx_nx >= OE_OFF));
        end
      end
    end
  end

endmodule

// File: rtl/mdio_shreg.sv
module mdio_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         rise_stb,
  input  logic         fall_stb,
  input  logic         cap_pin,
  input  logic         pin_in,
  output logic [W-1:0] q
);

  logic in_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      in_bit <= 1'b0;
    end else if (load) begin
      q <= load_val;
    end else begin
      if (rise_stb) in_bit <= pin_in;
      if (fall_stb) q <= {q[W-2:0], cap_pin ? in_bit : q[W-1]};
    end
  end

endmodule

// File: rtl/mdio_shift_master.sv
module mdio_shift_master
  import mdio_pkg::*;
#(
  parameter int FRAME_W  = 32,
  parameter int DATA_W   = 16,
  parameter int HALF_CYC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic [FRAME_W-1:0] bus_wdata,
  output logic [FRAME_W-1:0] bus_rdata,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i,
  output logic               done,
  output logic               irq
);

  localparam int OP_HI = FRAME_W - 3;
  localparam int OP_LO = FRAME_W - 4;

  logic busy;
  logic start;
  logic start_rd;
  logic rise_stb;
  logic fall_stb;
  logic cap_pin;

  assign start    = bus_wr && !busy;
  assign start_rd = (mdio_op_e'(bus_wdata[OP_HI:OP_LO]) == OP_READ);

  mdio_clk_div #(.HALF_CYC(HALF_CYC)) u_div (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_seq #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .start_rd (start_rd),
    .fall_stb (fall_stb),
    .busy     (busy),
    .cap_pin  (cap_pin),
    .oe       (mdio_oe),
    .done     (done),
    .irq      (irq)
  );

  mdio_shreg #(.W(FRAME_W)) u_sr (
    .clk      (clk),
    .rst      (rst),
    .load     (start),
    .load_val (bus_wdata),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .cap_pin  (cap_pin),
    .pin_in   (mdio_i),
    .q        (bus_rdata)
  );

  assign mdio_o = bus_rdata[FRAME_W-1];

endmodule

// File: rtl/mdio_shift_master_chk.sv
module mdio_shift_master_chk #(
  parameter int FRAME_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_wr,
  input logic               busy,
  input logic               done,
  input logic               irq,
  input logic               mdc,
  input logic               mdio_o,
  input logic               mdio_oe,
  input logic [FRAME_W-1:0] bus_rdata
);

  assert_irq_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    irq |-> done);

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(mdio_o) && !$fell(mdc)) |-> $past(bus_wr));

  assert_busy_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && !$fell(mdc)) |-> $stable(bus_rdata));

  assert_start_clears_done_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr) && !$past(busy)) |-> (busy && !done));

endmodule

bind mdio_shift_master mdio_shift_master_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .busy      (busy),
  .done      (done),
  .irq       (irq),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .bus_rdata (bus_rdata)
);

// File: tb/mdio_shift_master_test.sv
module mdio_shift_master_test;

  localparam int CLK_PERIOD = 10;
  localparam int FW         = 32;
  localparam int FRAME_CYC  = 2048;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus_wr = 1'b0;
  logic [FW-1:0] bus_wdata = '0;
  logic [FW-1:0] bus_rdata;
  logic          mdc, mdio_o, mdio_oe, mdio_i, done, irq;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;

  typedef struct {
    logic [FW-1:0] frame;
    logic [FW-1:0] expect_end;
    bit            rd;
    longint        t_irq;
  } item_t;
  item_t sb[$];

  // device stub
  logic [15:0] phy_val = '0;
  bit          noise = 1'b0;
  bit          stub_clr = 1'b0;
  int          rises = 0;
  logic        mdc_d = 1'b0;
  logic        phy_drv;

  mdio_shift_master uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .done(done), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    mdc_d <= mdc;
    if (stub_clr) rises <= 0;
    else if (mdc && !mdc_d) rises <= rises + 1;
  end

  always_comb begin
    if (rises >= 16 && rises <= 31) phy_drv = phy_val[4'(31 - rises)];
    else phy_drv = 1'b0;
  end
  assign mdio_i = mdio_oe ? (noise ? ~mdio_o : mdio_o) : phy_drv;

  task automatic check(input bit ok, input string req, input logic [FW-1:0] act,
                       input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] rotl(input logic [FW-1:0] v, input int n);
    if (n == 0) return v;
    return (v << n) | (v >> (FW - n));
  endfunction

  // monitor: bit capture at each management clock rise
  logic [FW-1:0] seen_o, seen_oe;
  int            mon_k = 0;
  longint        last_rise = -1;
  bit            irq_prev = 1'b0;
  logic          mon_mdc_d = 1'b0;

  always @(negedge clk) begin
    if (mdc && !mon_mdc_d) begin
      if (mon_k < FW) begin
        seen_o[FW-1-mon_k]  = mdio_o;
        seen_oe[FW-1-mon_k] = mdio_oe;
      end
      if (mon_k > 0)
        check((cyc - last_rise) == 64, "R3 mdc period", FW'(cyc - last_rise), FW'(64));
      last_rise = cyc;
      mon_k++;
    end
    mon_mdc_d = mdc;
    if (irq_prev) check(!irq && done, "R8 irq one cycle, done held", {30'd0, irq, done}, 32'd1);
    if (irq) begin
      if (sb.size() == 0) begin
        check(1'b0, "R8 unexpected irq", 32'd1, 32'd0);
      end else begin
        item_t it;
        logic [FW-1:0] exp_oe;
        it = sb.pop_front();
        exp_oe = it.rd ? {{15{1'b1}}, {17{1'b0}}} : '1;
        check(bus_rdata == it.expect_end, it.rd ? "R6 read data result" : "R5 rotation result",
              bus_rdata, it.expect_end);
        check(cyc == it.t_irq, "R8 completion time", FW'(cyc), FW'(it.t_irq));
        check(done, "R8 done set with irq", {31'd0, done}, 32'd1);
        check(seen_oe == exp_oe, "R7 output enable pattern", seen_oe, exp_oe);
        check((seen_o & exp_oe) == (it.frame & exp_oe), "R4 serial bits MSB first",
              seen_o & exp_oe, it.frame & exp_oe);
        check(mon_k == FW, "R3 mdc rise count", FW'(mon_k), FW'(FW));
      end
      mon_k = 0;
      last_rise = -1;
    end
    irq_prev = irq;
  end

  // driver: load a frame and push the expected outcome
  task automatic start_frame(input logic [FW-1:0] v, input logic [15:0] phy, input bit nz,
                             output longint t0);
    item_t it;
    @(negedge clk);
    phy_val   = phy;
    noise     = nz;
    stub_clr  = 1'b1;
    bus_wr    = 1'b1;
    bus_wdata = v;
    @(negedge clk);
    bus_wr   = 1'b0;
    stub_clr = 1'b0;
    t0 = cyc;
    it.frame = v;
    it.rd    = (v[29:28] == 2'b10);
    it.expect_end = it.rd ? {v[31:16], phy} : v;
    it.t_irq = t0 + FRAME_CYC;
    sb.push_back(it);
    check(bus_rdata == v, "R2 load readback", bus_rdata, v);
    check(!done, "R2 done cleared at start", {31'd0, done}, 32'd0);
    check(mdio_oe, "R7 oe high at frame start", {31'd0, mdio_oe}, 32'd1);
    check(!mdc, "R3 starts with low half", {31'd0, mdc}, 32'd0);
  endtask

  task automatic wait_empty();
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint t0;
    logic [FW-1:0] v;
    repeat (3) @(negedge clk);
    check(bus_rdata == '0, "R1 reset register", bus_rdata, '0);
    check({done, irq, mdc, mdio_oe} == 4'b0, "R1 reset outputs",
          {28'd0, done, irq, mdc, mdio_oe}, '0);
    rst = 1'b0;
    @(negedge clk);
    check(bus_rdata == '0 && !done, "R1 after reset", bus_rdata, '0);

    // write op with a disagreeing pin
    start_frame({2'b01, 2'b01, 5'h03, 5'h11, 2'b10, 16'hA5C3}, 16'h0, 1'b1, t0);
    wait_empty();
    check(done, "R8 done stays set while idle", {31'd0, done}, 32'd1);

    // read op
    start_frame({2'b01, 2'b10, 5'h1F, 5'h02, 2'b10, 16'h0000}, 16'hBEEF, 1'b0, t0);
    wait_empty();

    // read op with stale data field
    start_frame({2'b01, 2'b10, 5'h05, 5'h1A, 2'b10, 16'hFFFF}, 16'h1234, 1'b0, t0);
    wait_empty();

    // live read and a write while busy
    v = {2'b01, 2'b01, 5'h0A, 5'h15, 2'b10, 16'h3C96};
    start_frame(v, 16'h0, 1'b0, t0);
    while (cyc < t0 + 5 * 64 + 2) @(negedge clk);
    check(bus_rdata == rotl(v, 5), "R9 live contents after 5 shifts", bus_rdata, rotl(v, 5));
    bus_wr = 1'b1;
    bus_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    check(bus_rdata == rotl(v, 5), "R10 busy write ignored", bus_rdata, rotl(v, 5));
    wait_empty();

    // reserved op code behaves as a non-read frame
    start_frame({2'b01, 2'b11, 5'h11, 5'h07, 2'b10, 16'h5AA5}, 16'hFFFF, 1'b1, t0);
    wait_empty();

    check(sb.size() == 0 && !irq, "R8 all frames completed", FW'(sb.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule